// File: doc/BRIEF.md
# Double-Buffered Quad Converter Code Register Interface

This block is the digital front end of a four-channel, 12-bit voltage-output converter. A host shifts a 16-bit command word in serially. The shift register advances on each rising edge of the logical OR of an active-low select and a serial clock. Two active-low, level-sensitive strobes then move the data onward. The first opens the input register named by the word's channel field. The second opens all four output code registers at once, so several channels can be staged and then changed together.

Both register stages behave as transparent latches. The block samples the level of every control on a fast system clock, and while a strobe is low the register behind it follows its source cycle by cycle. An active-low asynchronous reset loads every input and output register with either zero-scale or mid-scale. A select input picks which. The reset does not touch the serial shift register. The four 12-bit output codes drive the analog ladders, which sit outside this block.

Top module: `quad_dac_regif`

## Requirements
- R1: While rst_ni is low, every input register and every output code is forced to 0x000 when rst_sel_i is 0, or to 0x800 when rst_sel_i is 1.
- R2: The command word is 16 bits, sent most significant bit first: channel address (2 bits, first bit is the MSB), then 2 bits that are ignored, then the 12-bit code, MSB first. Address value n selects channel n, which appears on code_o[12n+11:12n].
- R3: The shift register advances one bit, taking sdi_i, on every rising edge of (cs_ni OR sclk_i). The shift register is otherwise unchanged. A word can be clocked with cs_ni while sclk_i is held low.
- R4: If cs_ni rises while sclk_i is low at the end of a word, one more bit is shifted in. The word then written uses the shifted address and code.
- R5: While ld_in_ni is low, the input register addressed by the word follows the word's code field. While ld_in_ni is high, all input registers hold, and staging a code does not change code_o while ld_out_ni is high.
- R6: If bits are shifted while ld_in_ni is low, each input register that the moving address field selects along the way takes the code field present while it is selected.
- R7: While ld_out_ni is low, all four output codes follow their input registers. While ld_out_ni is high, code_o holds.
- R8: Asserting reset leaves the serial shift register unchanged, so a word shifted before reset can be loaded after it.
- R9: When reset is released, registers whose strobe is high keep the reset code. Registers whose strobe is low take their sources at once.
- R10: Only the last 16 bits shifted matter. Earlier bits are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample all control levels |
| rst_ni | input | 1 | Asynchronous active-low reset of the code registers |
| rst_sel_i | input | 1 | Reset code select: 0 gives 0x000, 1 gives 0x800 |
| cs_ni | input | 1 | Active-low select, ORed with sclk_i to clock the shifter |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data |
| ld_in_ni | input | 1 | Active-low strobe: addressed input register transparent |
| ld_out_ni | input | 1 | Active-low strobe: all output code registers transparent |
| code_o | output | 48 | Four 12-bit output codes, channel 0 in the low bits |

## Verification
Two functions can fall in the same cycle. Shifting can occur while an input strobe is open, and a reset release can occur while both strobes are open. The bench provokes the first by holding ld_in_ni low and clocking a whole word through. Each register that the moving address field passes over is then judged against a behavioural model that replays the walk. The second is provoked by opening both strobes during reset and then releasing it. The check is that the channel addressed by the surviving word takes its code, while every other channel keeps the reset value. Each result is also converted to an ideal output voltage and compared on that scale.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int DEF_CH  = 4;
  localparam int DEF_CW  = 12;
  localparam int DEF_PAD = 2;
endpackage

// File: rtl/qdr_shifter.sv
module qdr_shifter #(
  parameter int AW    = 2,
  parameter int PAD_W = 2,
  parameter int CW    = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          sclk_i,
  input  logic          sdi_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] data_o
);
  localparam int WW = AW + PAD_W + CW;

  logic          or_w, or_q;
  logic [WW-1:0] sr_q;

  assign or_w = cs_ni | sclk_i;

  // previous OR level; held high in reset so no edge is seen and sr_q is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) or_q <= 1'b1;
    else         or_q <= or_w;
  end

  always_ff @(posedge clk_i) begin
    if (or_w && !or_q) sr_q <= {sr_q[WW-2:0], sdi_i};
  end

  assign addr_o = sr_q[WW-1 -: AW];
  assign data_o = sr_q[CW-1:0];
endmodule

// File: rtl/qdr_in_bank.sv
module qdr_in_bank #(
  parameter int NCH = 4,
  parameter int CW  = 12,
  parameter int AW  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     rst_code_i,
  input  logic              ld_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [CW-1:0]     data_i,
  output logic [NCH*CW-1:0] regs_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= rst_code_i;
      else if (!ld_ni && addr_i == AW'(i))   q <= data_i;
    end
    assign regs_o[i*CW +: CW] = q;
  end
endmodule

// File: rtl/qdr_out_bank.sv
module qdr_out_bank #(
  parameter int NCH = 4,
  parameter int CW  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     rst_code_i,
  input  logic              ld_ni,
  input  logic [NCH*CW-1:0] d_i,
  output logic [NCH*CW-1:0] q_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= rst_code_i;
      else if (!ld_ni) q <= d_i[i*CW +: CW];
    end
    assign q_o[i*CW +: CW] = q;
  end
endmodule

// File: rtl/quad_dac_regif.sv
module quad_dac_regif
  import qdr_pkg::*;
#(
  parameter int NCH   = DEF_CH,
  parameter int CW    = DEF_CW,
  parameter int PAD_W = DEF_PAD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_sel_i,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              ld_in_ni,
  input  logic              ld_out_ni,
  output logic [NCH*CW-1:0] code_o
);
  localparam int AW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [CW-1:0]     rst_code_w;
  logic [AW-1:0]     addr_w;
  logic [CW-1:0]     data_w;
  logic [NCH*CW-1:0] in_flat_w;

  // zero-scale or mid-scale
  assign rst_code_w = {rst_sel_i, {(CW-1){1'b0}}};

  qdr_shifter #(.AW(AW), .PAD_W(PAD_W), .CW(CW)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .sclk_i (sclk_i),
    .sdi_i  (sdi_i),
    .addr_o (addr_w),
    .data_o (data_w)
  );

  qdr_in_bank #(.NCH(NCH), .CW(CW), .AW(AW)) u_in (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_code_i (rst_code_w),
    .ld_ni      (ld_in_ni),
    .addr_i     (addr_w),
    .data_i     (data_w),
    .regs_o     (in_flat_w)
  );

  qdr_out_bank #(.NCH(NCH), .CW(CW)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_code_i (rst_code_w),
    .ld_ni      (ld_out_ni),
    .d_i        (in_flat_w),
    .q_o        (code_o)
  );
endmodule

// File: rtl/qdr_checker.sv
module qdr_checker #(
  parameter int NCH = 4,
  parameter int CW  = 12,
  parameter int AW  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rst_sel_i,
  input logic              cs_ni,
  input logic              sclk_i,
  input logic              ld_in_ni,
  input logic              ld_out_ni,
  input logic [AW-1:0]     addr_i,
  input logic [CW-1:0]     data_i,
  input logic [NCH*CW-1:0] in_i,
  input logic [NCH*CW-1:0] code_i
);
  logic          or_w;
  logic [CW-1:0] exp_rst;
  assign or_w    = cs_ni | sclk_i;
  assign exp_rst = rst_sel_i ? CW'(1 << (CW-1)) : '0;

  assert_reset_code_R1: assert property (@(posedge clk_i) disable iff (rst_ni)
    ($past(!rst_ni) && $stable(rst_sel_i)) |-> (code_i == {NCH{exp_rst}} && in_i == {NCH{exp_rst}}));

  assert_shift_only_on_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($past(or_w) && !$past(or_w, 2)) |-> ($stable(addr_i) && $stable(data_i)));

  assert_input_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ld_in_ni) |-> $stable(in_i));

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assert_input_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !$past(ld_in_ni) && $past(addr_i) == AW'(i))
        |-> in_i[i*CW +: CW] == $past(data_i));
  end

  assert_output_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ld_out_ni) |-> $stable(code_i));

  assert_output_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(ld_out_ni)) |-> code_i == $past(in_i));
endmodule

bind quad_dac_regif qdr_checker #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rst_sel_i (rst_sel_i),
  .cs_ni     (cs_ni),
  .sclk_i    (sclk_i),
  .ld_in_ni  (ld_in_ni),
  .ld_out_ni (ld_out_ni),
  .addr_i    (addr_w),
  .data_i    (data_w),
  .in_i      (in_flat_w),
  .code_i    (code_o)
);

// File: tb/sim_quad_dac_regif.sv
module sim_quad_dac_regif;
  localparam real VLO = -2.5;
  localparam real VHI = 2.5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1, rst_sel_i = 1'b0;
  logic        cs_ni = 1'b1, sclk_i = 1'b1, sdi_i = 1'b0;
  logic        ld_in_ni = 1'b1, ld_out_ni = 1'b1;
  logic [47:0] code_o;

  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  quad_dac_regif u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sel_i(rst_sel_i), .cs_ni(cs_ni),
    .sclk_i(sclk_i), .sdi_i(sdi_i), .ld_in_ni(ld_in_ni), .ld_out_ni(ld_out_ni),
    .code_o(code_o)
  );

  // behavioural reference
  logic [15:0] m_sr = '0;
  logic [11:0] m_in[4];
  logic [11:0] m_out[4];
  bit          m_prev = 1'b1;

  typedef struct { int ch; logic [11:0] exp; string req; } item_t;
  item_t sb_q[$];

  task automatic model_step();
    logic o;
    o = cs_ni | sclk_i;
    if (!rst_ni) begin
      m_prev = 1'b1;
      for (int c = 0; c < 4; c++) begin
        m_in[c]  = rst_sel_i ? 12'h800 : 12'h000;
        m_out[c] = rst_sel_i ? 12'h800 : 12'h000;
      end
    end else begin
      if (o && !m_prev) m_sr = {m_sr[14:0], sdi_i};
      m_prev = o;
      if (!ld_in_ni) m_in[m_sr[15:14]] = m_sr[11:0];
      if (!ld_out_ni) for (int c = 0; c < 4; c++) m_out[c] = m_in[c];
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      model_step();
      @(negedge clk_i);
    end
  endtask

  task automatic expect_all(input string req);
    tick(4);
    for (int c = 0; c < 4; c++) begin
      item_t it;
      it.ch = c; it.exp = m_out[c]; it.req = req;
      sb_q.push_back(it);
    end
    @(negedge clk_i);
  endtask

  // monitor: pops expected items and compares with the outputs
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [11:0] act;
      real va, ve;
      it  = sb_q.pop_front();
      act = code_o[it.ch*12 +: 12];
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s ch%0d code actual 0x%03h expected 0x%03h", it.req, it.ch, act, it.exp);
      end
      va = VLO + (VHI - VLO) * real'(act) / 4096.0;
      ve = VLO + (VHI - VLO) * real'(it.exp) / 4096.0;
      checks++;
      if (va > ve + 1e-9 || va < ve - 1e-9) begin
        errors++;
        $display("FAIL %s ch%0d level actual %f expected %f", it.req, it.ch, va, ve);
      end
    end
  end

  function automatic logic [15:0] mk(input int a, input logic [1:0] pad, input logic [11:0] c);
    return {a[1:0], pad, c};
  endfunction

  // n bits of w (MSB first); via_cs clocks with cs_ni, end_low raises cs_ni with sclk_i low
  task automatic send(input logic [31:0] w, input int n, input bit via_cs, input bit end_low, input bit eb);
    if (via_cs) begin
      sclk_i = 1'b0; tick();
      for (int i = n - 1; i >= 0; i--) begin
        cs_ni = 1'b0; sdi_i = w[i]; tick();
        cs_ni = 1'b1; tick();
      end
      sclk_i = 1'b1; tick();
    end else begin
      cs_ni = 1'b0; tick();
      for (int i = n - 1; i >= 0; i--) begin
        sclk_i = 1'b0; sdi_i = w[i]; tick();
        sclk_i = 1'b1; tick();
      end
      if (end_low) begin sclk_i = 1'b0; sdi_i = eb; tick(); end
      cs_ni = 1'b1; tick();
      sclk_i = 1'b1; tick();
    end
  endtask

  task automatic pulse_in();  ld_in_ni = 1'b0;  tick(2); ld_in_ni = 1'b1;  tick(); endtask
  task automatic pulse_out(); ld_out_ni = 1'b0; tick(2); ld_out_ni = 1'b1; tick(); endtask

  initial begin
    #2 rst_ni = 1'b0;
    @(negedge clk_i);
    tick(2);
    expect_all("R1 zero-scale");
    rst_ni = 1'b1; tick(2);
    expect_all("R9 latched keep reset");

    rst_sel_i = 1'b1; rst_ni = 1'b0; tick(3);
    expect_all("R1 mid-scale");
    rst_ni = 1'b1; tick();
    pulse_out();
    expect_all("R1 input regs mid-scale");

    // staging then simultaneous update; pad bits set to 1 on ch2
    send(32'(mk(0, 2'b00, 12'h123)), 16, 0, 0, 0); pulse_in();
    send(32'(mk(1, 2'b00, 12'hFED)), 16, 0, 0, 0); pulse_in();
    send(32'(mk(2, 2'b11, 12'h0F0)), 16, 0, 0, 0); pulse_in();
    send(32'(mk(3, 2'b00, 12'hA5A)), 16, 0, 0, 0); pulse_in();
    expect_all("R5 staged no output change");
    pulse_out();
    expect_all("R2 R7 all channels updated");

    // output strobe held low: channel 1 follows directly
    ld_out_ni = 1'b0; tick();
    send(32'(mk(1, 2'b01, 12'h777)), 16, 0, 0, 0); pulse_in();
    expect_all("R7 transparent output");
    ld_out_ni = 1'b1; tick();
    send(32'(mk(0, 2'b00, 12'hBBB)), 16, 0, 0, 0);
    pulse_in();
    expect_all("R7 hold while strobe high");
    pulse_out();

    // clocking with select only
    send(32'(mk(3, 2'b00, 12'h3C5)), 16, 1, 0, 0); pulse_in(); pulse_out();
    expect_all("R3 clocked by cs_ni");

    // select rises while clock low: extra bit
    send(32'(mk(1, 2'b00, 12'h3C3)), 16, 0, 1, 1); pulse_in(); pulse_out();
    expect_all("R4 extra shift");

    // shifting with input strobe open corrupts channels on the way
    send(32'(mk(0, 2'b00, 12'h111)), 16, 0, 0, 0);
    ld_in_ni = 1'b0; tick();
    send(32'(mk(3, 2'b10, 12'hABC)), 16, 0, 0, 0);
    ld_in_ni = 1'b1; tick();
    pulse_out();
    expect_all("R6 corruption walk");

    // 20 bits: only the last 16 count
    send({12'h000, 4'b1011, mk(2, 2'b00, 12'h5E1)}, 20, 0, 0, 0); pulse_in(); pulse_out();
    expect_all("R10 last sixteen bits");

    // reset keeps the shifter; strobes open at release
    send(32'(mk(2, 2'b00, 12'h5A5)), 16, 0, 0, 0);
    rst_sel_i = 1'b0; rst_ni = 1'b0; tick(2);
    ld_in_ni = 1'b0; ld_out_ni = 1'b0; tick(2);
    rst_ni = 1'b1; tick(2);
    ld_in_ni = 1'b1; ld_out_ni = 1'b1;
    expect_all("R8 R9 shifter kept, open strobes load");

    tick(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule